// File: doc/BRIEF.md
# Decode-Stage Branch Controller with Canceling Delay Slot

This block steers instruction fetch for a five-stage pipeline whose branches resolve in the decode stage. A branch tests one register against zero. A dedicated adder forms the taken target from the incremented PC of the branch and its sign-extended 16-bit displacement. Both results are ready before decode ends, so a redirect costs one fetch slot. By default fetch advances sequentially. When a branch leaves decode taken, the block selects the target as the next fetch address.

Two behaviours are available through a mode input. In delayed mode, the instruction after a branch always issues. If the branch is canceling, a direction hint carried in the instruction decides whether that follower completes or becomes a no-op. In flush mode, the follower was fetched on a not-taken guess, and it is discarded whenever the branch turns out taken.

A discarded follower enters the decode/execute buffer with its valid and register-write bits cleared. The block holds that buffer's two control bits itself. While decode is held by an interlock, any pending decision waits, and the buffer receives a bubble.

Top module: `ebr_ctl`

## Requirements
- R1: A branch is taken when it is unconditional, or when its polarity bit is 0 and the register equals zero, or when its polarity bit is 1 and the register is non-zero.
- R2: In a cycle where a valid, non-discarded branch leaves decode (stall low) taken, `redirect_o` is 1 and `next_pc_o` equals `id_pc4_i` plus the sign-extended `offset_i`. In every other cycle `redirect_o` is 0 and `next_pc_o` equals `if_pc4_i`.
- R3: While `id_stall_i` is 1, no redirect is issued, and the pending-discard flag `slot_kill_o` keeps its value. The decision for a stalled branch is made in the cycle it leaves decode.
- R4: With `mode_i`=0, a non-canceling conditional branch never discards its follower.
- R5: With `mode_i`=0, a canceling conditional branch discards its follower exactly when its outcome differs from its hint bit (1 = predicted taken).
- R6: With `mode_i`=0, an unconditional branch never discards its follower, whatever its cancel and hint bits.
- R7: With `mode_i`=1, a taken branch discards its follower and a not-taken branch does not. The cancel and hint bits have no effect.
- R8: A discard decision raises `slot_kill_o` from the next cycle. It stays raised until the next instruction in decode leaves (stall low). At that edge the instruction enters execute with `ex_valid_o`=0 and `ex_wr_en_o`=0, and `slot_kill_o` falls.
- R9: A branch being discarded (`slot_kill_o`=1) neither redirects nor discards its own follower.
- R10: During reset, `ex_valid_o`, `ex_wr_en_o` and `slot_kill_o` are 0.
- R11: An edge taken with `id_stall_i`=1 loads a bubble (`ex_valid_o`=0, `ex_wr_en_o`=0) into the buffer.
- R12: Otherwise, on each edge `ex_valid_o` takes `id_valid_i` and `ex_wr_en_o` takes `id_valid_i & id_wr_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_i | input | 1 | 0 = delayed slot with optional canceling, 1 = flush on taken |
| id_valid_i | input | 1 | Decode holds a valid instruction |
| id_wr_en_i | input | 1 | Decode instruction writes a register |
| id_stall_i | input | 1 | Decode held by a data interlock |
| br_en_i | input | 1 | Decode instruction is a branch |
| br_uncond_i | input | 1 | Branch is unconditional |
| br_on_nz_i | input | 1 | Polarity: 0 = taken on zero, 1 = taken on non-zero |
| br_cancel_i | input | 1 | Branch is canceling |
| br_pred_i | input | 1 | Hint bit, 1 = predicted taken |
| rs_val_i | input | 32 | Tested register value |
| offset_i | input | 16 | Branch displacement, two's complement |
| id_pc4_i | input | 32 | Incremented PC of the decode instruction |
| if_pc4_i | input | 32 | Sequential next fetch address |
| next_pc_o | output | 32 | Next fetch address |
| redirect_o | output | 1 | Fetch redirected to the branch target |
| slot_kill_o | output | 1 | Instruction now in decode will be discarded |
| ex_valid_o | output | 1 | Decode/execute buffer valid bit |
| ex_wr_en_o | output | 1 | Decode/execute buffer register-write bit |

## Verification
Directed sequences apply each of the four hint/outcome combinations of a canceling branch in delayed mode. The same cases are then replayed in flush mode, which shows that the discard follows the mode and not the hint. Both polarities are tried with zero and non-zero register values. Negative and positive displacements check sign extension in the target. Stall runs are placed over a branch and, separately, over a follower that is due to be discarded; these show that the decision waits for the stall and survives it. A discarded follower that is itself a taken branch checks that it is inert. A long pseudo-random mix of all inputs, in both modes, is compared each cycle against a behavioural model.

// File: rtl/ebr_pkg.sv
`timescale 1ns/1ps
package ebr_pkg;
  typedef enum logic {
    MODE_DELAYED = 1'b0,
    MODE_FLUSH   = 1'b1
  } br_mode_e;

  typedef struct packed {
    logic en;
    logic uncond;
    logic on_nz;
    logic cancel;
    logic pred;
  } br_ctl_t;
endpackage

// File: rtl/ebr_cond.sv
`timescale 1ns/1ps
// Zero test on the branch register, evaluated in decode.
module ebr_cond #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] rs_val_i,
  input  logic            on_nz_i,
  input  logic            uncond_i,
  output logic            taken_o
);
  logic is_zero;

  always_comb begin
    is_zero = (rs_val_i == '0);
    taken_o = uncond_i | (is_zero ^ on_nz_i);
  end
endmodule

// File: rtl/ebr_target.sv
`timescale 1ns/1ps
// Dedicated decode-stage target adder.
module ebr_target #(
  parameter int XLEN  = 32,
  parameter int OFFW  = 16,
  parameter int SHIFT = 0
) (
  input  logic [XLEN-1:0] pc4_i,
  input  logic [OFFW-1:0] off_i,
  output logic [XLEN-1:0] target_o
);
  localparam int EXTW = XLEN - OFFW;

  logic [XLEN-1:0] sext;

  always_comb begin
    sext     = {{EXTW{off_i[OFFW-1]}}, off_i};
    target_o = pc4_i + (sext << SHIFT);
  end
endmodule

// File: rtl/ebr_decide.sv
`timescale 1ns/1ps
// Decides whether the instruction behind a resolving branch is discarded.
module ebr_decide
  import ebr_pkg::*;
(
  input  br_mode_e mode_i,
  input  logic     act_i,
  input  logic     taken_i,
  input  logic     cancel_i,
  input  logic     uncond_i,
  input  logic     pred_i,
  output logic     kill_req_o
);
  logic mismatch;
  logic kill;

  always_comb begin
    mismatch = taken_i ^ pred_i;
    kill     = 1'b0;
    case (mode_i)
      MODE_FLUSH:   kill = taken_i;
      MODE_DELAYED: kill = cancel_i & ~uncond_i & mismatch;
      default:      kill = 1'b0;
    endcase
    kill_req_o = act_i & kill;
  end
endmodule

// File: rtl/ebr_slot.sv
`timescale 1ns/1ps
// Pending-discard flag and the decode/execute buffer control bits.
module ebr_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic stall_i,
  input  logic valid_i,
  input  logic wr_en_i,
  input  logic kill_req_i,
  output logic slot_kill_o,
  output logic ex_valid_o,
  output logic ex_wr_en_o
);
  logic kill_q, kill_d, kill_en;
  logic exv_q, exv_d;
  logic exw_q, exw_d;

  always_comb begin
    kill_en = ~stall_i;
    kill_d  = kill_req_i;
    if (stall_i) begin
      exv_d = 1'b0;
      exw_d = 1'b0;
    end else begin
      exv_d = valid_i & ~kill_q;
      exw_d = valid_i & wr_en_i & ~kill_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kill_q <= 1'b0;
      exv_q  <= 1'b0;
      exw_q  <= 1'b0;
    end else begin
      if (kill_en) kill_q <= kill_d;
      exv_q <= exv_d;
      exw_q <= exw_d;
    end
  end

  assign slot_kill_o = kill_q;
  assign ex_valid_o  = exv_q;
  assign ex_wr_en_o  = exw_q;

  p_kill_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_kill_o && !stall_i) |=> (!ex_valid_o && !ex_wr_en_o && !slot_kill_o));

  p_kill_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(slot_kill_o));

  p_stall_bubble_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> !ex_valid_o);

  p_wr_needs_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ex_wr_en_o |-> ex_valid_o);
endmodule

// File: rtl/ebr_ctl.sv
`timescale 1ns/1ps
// Top: decode-stage branch resolution with canceling delay slot.
module ebr_ctl
  import ebr_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int OFFW      = 16,
  parameter int OFF_SHIFT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_i,
  input  logic            id_valid_i,
  input  logic            id_wr_en_i,
  input  logic            id_stall_i,
  input  logic            br_en_i,
  input  logic            br_uncond_i,
  input  logic            br_on_nz_i,
  input  logic            br_cancel_i,
  input  logic            br_pred_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [OFFW-1:0] offset_i,
  input  logic [XLEN-1:0] id_pc4_i,
  input  logic [XLEN-1:0] if_pc4_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            redirect_o,
  output logic            slot_kill_o,
  output logic            ex_valid_o,
  output logic            ex_wr_en_o
);
  br_mode_e        mode;
  br_ctl_t         ctl;
  logic            taken;
  logic            act;
  logic            kill_req;
  logic [XLEN-1:0] target;

  always_comb begin
    mode = br_mode_e'(mode_i);
    ctl  = '{en: br_en_i, uncond: br_uncond_i, on_nz: br_on_nz_i,
             cancel: br_cancel_i, pred: br_pred_i};
  end

  ebr_cond #(.XLEN(XLEN)) u_cond (
    .rs_val_i (rs_val_i),
    .on_nz_i  (ctl.on_nz),
    .uncond_i (ctl.uncond),
    .taken_o  (taken)
  );

  ebr_target #(.XLEN(XLEN), .OFFW(OFFW), .SHIFT(OFF_SHIFT)) u_target (
    .pc4_i    (id_pc4_i),
    .off_i    (offset_i),
    .target_o (target)
  );

  // A branch acts only when it is live and leaves decode this cycle.
  always_comb begin
    act        = id_valid_i & ctl.en & ~slot_kill_o & ~id_stall_i;
    redirect_o = act & taken;
    next_pc_o  = redirect_o ? target : if_pc4_i;
  end

  ebr_decide u_decide (
    .mode_i     (mode),
    .act_i      (act),
    .taken_i    (taken),
    .cancel_i   (ctl.cancel),
    .uncond_i   (ctl.uncond),
    .pred_i     (ctl.pred),
    .kill_req_o (kill_req)
  );

  ebr_slot u_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_i     (id_stall_i),
    .valid_i     (id_valid_i),
    .wr_en_i     (id_wr_en_i),
    .kill_req_i  (kill_req),
    .slot_kill_o (slot_kill_o),
    .ex_valid_o  (ex_valid_o),
    .ex_wr_en_o  (ex_wr_en_o)
  );

  p_stall_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    id_stall_i |-> (!redirect_o && next_pc_o == if_pc4_i));

  p_uncond_redirect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid_i && br_en_i && br_uncond_i && !id_stall_i && !slot_kill_o) |-> redirect_o);

  p_flush_taken_kills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && redirect_o) |=> slot_kill_o);

  p_uncond_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && redirect_o && br_uncond_i) |=> !slot_kill_o);

  p_killed_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_kill_o |-> !redirect_o);

  p_redirect_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (next_pc_o == target));
endmodule

// File: tb/ebr_ctl_bench.sv
`timescale 1ns/1ps
module ebr_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode, id_valid, id_wr_en, id_stall;
  logic        br_en, br_uncond, br_on_nz, br_cancel, br_pred;
  logic [31:0] rs_val, id_pc4, if_pc4;
  logic [15:0] offset;
  logic [31:0] next_pc;
  logic        redirect, slot_kill, ex_valid, ex_wr_en;

  int n_vec  = 0;
  int n_fail = 0;
  bit m_kill, m_exv, m_exw;
  logic [31:0] pc_ctr = 32'h0000_1000;

  always #5 clk = ~clk;

  ebr_ctl u_ebr_ctl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .id_valid_i(id_valid), .id_wr_en_i(id_wr_en), .id_stall_i(id_stall),
    .br_en_i(br_en), .br_uncond_i(br_uncond), .br_on_nz_i(br_on_nz),
    .br_cancel_i(br_cancel), .br_pred_i(br_pred),
    .rs_val_i(rs_val), .offset_i(offset), .id_pc4_i(id_pc4), .if_pc4_i(if_pc4),
    .next_pc_o(next_pc), .redirect_o(redirect), .slot_kill_o(slot_kill),
    .ex_valid_o(ex_valid), .ex_wr_en_o(ex_wr_en)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  // One cycle: drive, compare against the behavioural model, advance the model.
  task automatic step(string tag, bit v, bit w, bit st, bit en, bit un, bit nz,
                      bit ca, bit pr, logic [31:0] rs, logic [15:0] off);
    bit taken, live, exp_redir, exp_kreq;
    logic [31:0] exp_pc;
    @(negedge clk);
    id_valid = v; id_wr_en = w; id_stall = st; br_en = en; br_uncond = un;
    br_on_nz = nz; br_cancel = ca; br_pred = pr; rs_val = rs; offset = off;
    id_pc4 = pc_ctr; if_pc4 = pc_ctr + 32'd4; pc_ctr = pc_ctr + 32'd4;
    #2;
    taken     = un || (nz ? (rs != 0) : (rs == 0));
    live      = v && en && !m_kill && !st;
    exp_redir = live && taken;
    exp_pc    = exp_redir ? (id_pc4 + {{16{off[15]}}, off}) : if_pc4;
    if (mode) exp_kreq = live && taken;
    else      exp_kreq = live && ca && !un && (taken != pr);
    n_vec++;
    chk(tag, "redirect", {31'd0, redirect}, {31'd0, exp_redir});
    chk(tag, "next_pc", next_pc, exp_pc);
    chk(tag, "slot_kill", {31'd0, slot_kill}, {31'd0, m_kill});
    chk(tag, "ex_valid", {31'd0, ex_valid}, {31'd0, m_exv});
    chk(tag, "ex_wr_en", {31'd0, ex_wr_en}, {31'd0, m_exw});
    @(posedge clk);
    if (st) begin
      m_exv = 1'b0; m_exw = 1'b0;
    end else begin
      m_exv  = v && !m_kill;
      m_exw  = v && w && !m_kill;
      m_kill = exp_kreq;
    end
  endtask

  task automatic plain(string tag);
    step(tag, 1, 1, 0, 0, 0, 0, 0, 0, 32'h5, 16'h0);
  endtask

  task automatic branch(string tag, bit un, bit nz, bit ca, bit pr,
                        logic [31:0] rs, logic [15:0] off);
    step(tag, 1, 0, 0, 1, un, nz, ca, pr, rs, off);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 1'b0;
    id_valid = 0; id_wr_en = 0; id_stall = 0; br_en = 0; br_uncond = 0;
    br_on_nz = 0; br_cancel = 0; br_pred = 0; rs_val = 0; offset = 0;
    id_pc4 = 0; if_pc4 = 0;
    repeat (3) @(posedge clk);
    #2;
    n_vec++;  // R10 reset state
    chk("R10", "ex_valid", {31'd0, ex_valid}, 32'd0);
    chk("R10", "ex_wr_en", {31'd0, ex_wr_en}, 32'd0);
    chk("R10", "slot_kill", {31'd0, slot_kill}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // Delayed mode
    mode = 1'b0;
    plain("R12");
    branch("R1", 0, 0, 0, 0, 32'h0, 16'hFFF0);        // taken on zero, negative offset
    plain("R4");                                       // kept follower
    plain("R4");
    branch("R1", 0, 0, 0, 1, 32'h7, 16'h0040);        // not taken on non-zero
    plain("R2");
    branch("R1", 0, 1, 0, 0, 32'h7, 16'h0100);        // polarity: taken on non-zero
    plain("R4");
    branch("R5", 0, 0, 1, 1, 32'h0, 16'h0020);        // hint taken, taken: keep
    plain("R5");
    branch("R5", 0, 0, 1, 1, 32'h3, 16'h0020);        // hint taken, not taken: discard
    plain("R5");
    plain("R8");
    branch("R5", 0, 0, 1, 0, 32'h0, 16'h8000);        // hint not taken, taken: discard
    plain("R5");
    plain("R8");
    branch("R5", 0, 0, 1, 0, 32'h9, 16'h0010);        // hint not taken, not taken: keep
    plain("R5");
    branch("R6", 1, 0, 1, 0, 32'h9, 16'h0200);        // unconditional, canceling, hint 0
    plain("R6");
    plain("R6");
    // Stalled branch: decision waits (R3)
    step("R3", 1, 0, 1, 1, 0, 0, 1, 1, 32'h4, 16'h0030);
    step("R3", 1, 0, 1, 1, 0, 0, 1, 1, 32'h4, 16'h0030);
    step("R3", 1, 0, 0, 1, 0, 0, 1, 1, 32'h4, 16'h0030);
    // Follower due for discard held by stall (R8, R11)
    step("R11", 1, 1, 1, 0, 0, 0, 0, 0, 32'h1, 16'h0);
    step("R11", 1, 1, 1, 0, 0, 0, 0, 0, 32'h1, 16'h0);
    step("R8", 1, 1, 0, 0, 0, 0, 0, 0, 32'h1, 16'h0);
    plain("R8");
    // Discarded follower is itself a taken branch (R9)
    branch("R9", 0, 0, 1, 0, 32'h0, 16'h0044);
    branch("R9", 1, 0, 0, 0, 32'h0, 16'h0400);
    plain("R9");
    plain("R9");

    // Flush mode (R7)
    mode = 1'b1;
    plain("R7");
    branch("R7", 0, 0, 0, 0, 32'h0, 16'h0050);        // taken: discard
    plain("R7");
    plain("R7");
    branch("R7", 0, 0, 1, 1, 32'h0, 16'h0050);        // hint matches, still discard
    plain("R7");
    branch("R7", 0, 0, 1, 1, 32'h2, 16'h0050);        // not taken, hint mismatch: keep
    plain("R7");
    branch("R7", 1, 0, 0, 0, 32'h2, 16'hFFFC);        // unconditional: discard
    plain("R7");
    plain("R7");

    // Mixed pseudo-random traffic (R12 and all others)
    for (int i = 0; i < 1600; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (i % 400 == 0) mode = ~mode;
      step("R12", r[0] | r[1], r[2], (r[5:3] == 3'd0), r[6] & r[7], r[8] & r[9] & r[10],
           r[11], r[12], r[13], (r[14] ? 32'd0 : {16'd0, r[31:16]}), r[31:16]);
    end

    summary();
    $finish;
  end
endmodule